// File: doc/BRIEF.md
# Deficit Round Robin Input Arbiter

This block merges eight packet input queues into one output stream. Each queue gets a share of the output measured in bytes, so the share does not depend on how long its packets are. The block reads the length of each head-of-line packet from a field in that packet's first word and keeps it in a per-queue register. Each queue also has its own deficit counter.

A single pointer visits the queues in cyclic order. On a visit, the queue's counter gains one quantum, and the block grants the queue only if that credit covers the head packet. The granted packet then flows through unchanged, word by word, until its end-of-packet word is accepted. The quantum is a run-time input. A larger quantum moves the behaviour toward plain one-packet-per-turn round robin.

Top module: `drr_input_arbiter`

## Requirements
- R1: While reset is asserted, and right after it is released, no output word is valid and no input ready is high. Every deficit counter starts at zero. The first visit after reset goes to queue 0.
- R2: The head packet length is the unsigned field in bits [15:0] of the first word of a packet. Only this field is used when deciding a grant.
- R3: A visit adds the quantum to the visited queue's counter to form its credit. The head packet is granted when its length is less than or equal to that credit, and equality grants.
- R4: After a grant, the counter keeps the credit minus the granted packet's length. This remainder counts toward the queue's next visit.
- R5: When the head packet is longer than the credit, nothing is sent on that visit. The counter keeps the full credit and the pointer moves on.
- R6: A queue that has no packet when it is visited has its counter cleared to zero.
- R7: The pointer advances through the queues in index order and wraps from 7 to 0. A queue sends at most one packet per visit. A counter changes only on its own queue's visit.
- R8: A granted packet is forwarded whole before any other queue is served. At most one input ready is high at a time. While the output ready input is low, the output word is held and nothing is consumed.
- R9: Credit saturates at 65535 instead of wrapping.
- R10: With a quantum of 65535 and packets of at most 1500 bytes, the grant order equals plain round robin over the non-empty queues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| quantum | input | 16 | Bytes of credit added per visit |
| in_valid | input | 8 | Per-queue word valid |
| in_data | input | 512 | Per-queue word, queue i at bits [64*i+63:64*i] |
| in_eop | input | 8 | Per-queue last word of packet |
| in_ready | output | 8 | Per-queue word accepted when high with valid |
| out_valid | output | 1 | Output word valid |
| out_data | output | 64 | Output word |
| out_eop | output | 1 | Output word ends the packet |
| out_ready | input | 1 | Downstream accepts the word |

## Verification
Two things can happen in the same cycle. The end-of-packet word of one packet is accepted, clearing the length register, and the next packet's header from the same queue becomes visible in the bypass. This is provoked by queues that hold back-to-back packets while the output ready input toggles. The case is judged by whether the next grant, computed from the newly visible length, matches the order and per-queue byte totals of an independent packet-level model. A second coincidence is an empty visit that clears a counter still holding credit. The bench judges it by the delay until a newly loaded packet is granted.

// File: rtl/drr_pkg.sv
package drr_pkg;
   typedef enum logic {
      ST_VISIT = 1'b0,
      ST_SEND  = 1'b1
   } drr_state_e;
endpackage

// File: rtl/drr_hol_len.sv
module drr_hol_len #(
   parameter int DATA_W  = 64,
   parameter int LEN_W   = 16,
   parameter int LEN_LSB = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_eop,
   input  logic              in_accept,
   output logic              has_pkt,
   output logic [LEN_W-1:0]  pkt_len
);
   logic             hol_vld;
   logic [LEN_W-1:0] hol_len;
   logic [LEN_W-1:0] field;

   assign field = in_data[LEN_LSB +: LEN_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hol_vld <= 1'b0;
         hol_len <= '0;
      end else if (in_accept && in_eop) begin
         hol_vld <= 1'b0;
      end else if (in_valid && !hol_vld) begin
         hol_vld <= 1'b1;
         hol_len <= field;
      end
   end

   assign has_pkt = hol_vld || in_valid;
   assign pkt_len = hol_vld ? hol_len : field;
endmodule

// File: rtl/drr_deficit.sv
module drr_deficit #(
   parameter int DEF_W   = 16,
   parameter int LEN_W   = 16,
   parameter int QUANT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               visit,
   input  logic [QUANT_W-1:0] quantum,
   input  logic               has_pkt,
   input  logic [LEN_W-1:0]   pkt_len,
   output logic               fits,
   output logic [DEF_W-1:0]   deficit
);
   logic [DEF_W:0]   sum;
   logic [DEF_W-1:0] credit;
   logic [DEF_W-1:0] len_ext;

   assign sum     = {1'b0, deficit} + (DEF_W+1)'(quantum);
   assign credit  = sum[DEF_W] ? {DEF_W{1'b1}} : sum[DEF_W-1:0];
   assign len_ext = DEF_W'(pkt_len);
   assign fits    = has_pkt && (len_ext <= credit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         deficit <= '0;
      end else if (visit) begin
         if (!has_pkt)  deficit <= '0;
         else if (fits) deficit <= credit - len_ext;
         else           deficit <= credit;
      end
   end
endmodule

// File: rtl/drr_input_arbiter.sv
module drr_input_arbiter
   import drr_pkg::*;
#(
   parameter int NUM_Q   = 8,
   parameter int DATA_W  = 64,
   parameter int LEN_W   = 16,
   parameter int LEN_LSB = 0,
   parameter int DEF_W   = 16,
   parameter int QUANT_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [QUANT_W-1:0]      quantum,
   input  logic [NUM_Q-1:0]        in_valid,
   input  logic [NUM_Q*DATA_W-1:0] in_data,
   input  logic [NUM_Q-1:0]        in_eop,
   output logic [NUM_Q-1:0]        in_ready,
   output logic                    out_valid,
   output logic [DATA_W-1:0]       out_data,
   output logic                    out_eop,
   input  logic                    out_ready
);
   localparam int PTR_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
   localparam bit POW2  = (NUM_Q == (1 << PTR_W));

   if (NUM_Q < 2)                   begin : g_chk_q   $error("NUM_Q must be at least 2"); end
   if (LEN_LSB + LEN_W > DATA_W)    begin : g_chk_fld $error("length field outside word"); end
   if (LEN_W > DEF_W)               begin : g_chk_len $error("LEN_W exceeds DEF_W"); end
   if (QUANT_W > DEF_W)             begin : g_chk_qw  $error("QUANT_W exceeds DEF_W"); end

   drr_state_e             state;
   logic [PTR_W-1:0]       ptr_q;
   logic [PTR_W-1:0]       ptr_nxt;
   logic                   sending;
   logic                   last_xfer;
   logic [NUM_Q-1:0]       visit_en;
   logic [NUM_Q-1:0]       has_pkt;
   logic [NUM_Q-1:0]       fits;
   logic [NUM_Q-1:0]       accept;
   logic [NUM_Q*LEN_W-1:0] len_flat;
   logic [NUM_Q*DEF_W-1:0] deficit_flat;

   if (POW2) begin : g_ptr_pow2
      assign ptr_nxt = ptr_q + 1'b1;
   end else begin : g_ptr_wrap
      assign ptr_nxt = (ptr_q == PTR_W'(NUM_Q-1)) ? '0 : ptr_q + 1'b1;
   end

   assign sending   = (state == ST_SEND);
   assign out_valid = sending && in_valid[ptr_q];
   assign out_data  = in_data[ptr_q*DATA_W +: DATA_W];
   assign out_eop   = in_eop[ptr_q];
   assign last_xfer = out_valid && out_ready && out_eop;

   for (genvar gi = 0; gi < NUM_Q; gi++) begin : g_q
      assign visit_en[gi] = !sending && (ptr_q == PTR_W'(gi));
      assign in_ready[gi] = sending && out_ready && (ptr_q == PTR_W'(gi));
      assign accept[gi]   = in_valid[gi] && in_ready[gi];

      drr_hol_len #(
         .DATA_W (DATA_W),
         .LEN_W  (LEN_W),
         .LEN_LSB(LEN_LSB)
      ) u_len (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_valid (in_valid[gi]),
         .in_data  (in_data[gi*DATA_W +: DATA_W]),
         .in_eop   (in_eop[gi]),
         .in_accept(accept[gi]),
         .has_pkt  (has_pkt[gi]),
         .pkt_len  (len_flat[gi*LEN_W +: LEN_W])
      );

      drr_deficit #(
         .DEF_W  (DEF_W),
         .LEN_W  (LEN_W),
         .QUANT_W(QUANT_W)
      ) u_def (
         .clk    (clk),
         .rst_n  (rst_n),
         .visit  (visit_en[gi]),
         .quantum(quantum),
         .has_pkt(has_pkt[gi]),
         .pkt_len(len_flat[gi*LEN_W +: LEN_W]),
         .fits   (fits[gi]),
         .deficit(deficit_flat[gi*DEF_W +: DEF_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_VISIT;
         ptr_q <= '0;
      end else if (!sending) begin
         if (fits[ptr_q]) state <= ST_SEND;
         else             ptr_q <= ptr_nxt;
      end else if (last_xfer) begin
         state <= ST_VISIT;
         ptr_q <= ptr_nxt;
      end
   end
endmodule

// File: rtl/drr_arbiter_checker.sv
module drr_arbiter_checker #(
   parameter int NUM_Q = 8,
   parameter int DEF_W = 16,
   parameter int PTR_W = 3
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    sending,
   input logic [PTR_W-1:0]        ptr_q,
   input logic [NUM_Q-1:0]        visit_en,
   input logic [NUM_Q-1:0]        has_pkt,
   input logic [NUM_Q-1:0]        fits,
   input logic [NUM_Q*DEF_W-1:0]  deficit_flat,
   input logic [NUM_Q-1:0]        in_ready,
   input logic                    out_valid,
   input logic                    out_ready,
   input logic                    out_eop
);
   function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(NUM_Q-1)) ? '0 : p + 1'b1;
   endfunction

   function automatic logic [DEF_W-1:0] def_of(input logic [NUM_Q*DEF_W-1:0] f,
                                               input logic [PTR_W-1:0] idx);
      return f[idx*DEF_W +: DEF_W];
   endfunction

   p_one_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(in_ready));

   p_hold_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sending && !(out_valid && out_ready && out_eop) |=> sending && $stable(ptr_q));

   p_advance_after_eop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sending && out_valid && out_ready && out_eop |=> !sending && ptr_q == step($past(ptr_q)));

   p_grant_on_fit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !sending && fits[ptr_q] |=> sending && $stable(ptr_q));

   p_skip_short_credit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !sending && !fits[ptr_q] |=> !sending && ptr_q == step($past(ptr_q)));

   p_clear_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !sending && !has_pkt[ptr_q] |=> def_of(deficit_flat, $past(ptr_q)) == '0);

   for (genvar gi = 0; gi < NUM_Q; gi++) begin : g_quiet
      p_counter_only_on_visit_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !visit_en[gi] |=> $stable(deficit_flat[gi*DEF_W +: DEF_W]));
   end
endmodule

bind drr_input_arbiter drr_arbiter_checker #(
   .NUM_Q(NUM_Q),
   .DEF_W(DEF_W),
   .PTR_W(PTR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sending     (sending),
   .ptr_q       (ptr_q),
   .visit_en    (visit_en),
   .has_pkt     (has_pkt),
   .fits        (fits),
   .deficit_flat(deficit_flat),
   .in_ready    (in_ready),
   .out_valid   (out_valid),
   .out_ready   (out_ready),
   .out_eop     (out_eop)
);

// File: tb/tb_drr_input_arbiter.sv
module tb_drr_input_arbiter;
   localparam int NQ = 8;
   localparam int DW = 64;
   localparam int MAXP = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [15:0]   quantum = 16'd100;
   logic [NQ-1:0] in_valid = '0;
   logic [NQ*DW-1:0] in_data = '0;
   logic [NQ-1:0] in_eop = '0;
   logic [NQ-1:0] in_ready;
   logic          out_valid;
   logic [DW-1:0] out_data;
   logic          out_eop;
   logic          out_ready = 1'b1;

   always #2 clk = ~clk;

   drr_input_arbiter dut (
      .clk(clk), .rst_n(rst_n), .quantum(quantum),
      .in_valid(in_valid), .in_data(in_data), .in_eop(in_eop), .in_ready(in_ready),
      .out_valid(out_valid), .out_data(out_data), .out_eop(out_eop), .out_ready(out_ready)
   );

   int checks = 0;
   int fails  = 0;
   int plen [NQ][MAXP];
   int npk [NQ];
   int pidx [NQ];
   int widx [NQ];
   int exp_q [512];
   int exp_p [512];
   int exp_n = 0;
   int ord = 0;
   int got_bytes [NQ];
   bit in_pkt = 0;
   int cur_q = 0;
   int last_w = 0;
   int cur_len = 0;
   bit bad = 0;
   bit stall_en = 0;
   logic [NQ-1:0] acc = '0;
   logic [7:0] lfsr = 8'hA5;
   logic [15:0] seed = 16'h1D2B;
   string cur_req = "R7";
   bit prev_stall = 0;
   logic [DW-1:0] prev_data = '0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   function automatic int nwords(input int len);
      return (len + 7) / 8;
   endfunction

   function automatic logic [DW-1:0] mk_word(input int q, input int p, input int w, input int len);
      logic [DW-1:0] d;
      d = '0;
      d[15:0]  = (w == 0) ? 16'(len) : 16'd0;
      d[23:16] = 8'(q);
      d[31:24] = 8'(p);
      d[47:32] = 16'(w);
      return d;
   endfunction

   task automatic next_rand(output int v, input int maxv);
      seed = {seed[14:0], seed[15] ^ seed[13] ^ seed[12] ^ seed[10]};
      v = (int'(seed) % maxv) + 1;
   endtask

   // input driver: updates one time unit after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         for (int i = 0; i < NQ; i++) begin
            if (acc[i]) begin
               if (widx[i] == nwords(plen[i][pidx[i]]) - 1) begin
                  pidx[i]++;
                  widx[i] = 0;
               end else begin
                  widx[i]++;
               end
            end
         end
         for (int i = 0; i < NQ; i++) begin
            if (pidx[i] < npk[i]) begin
               in_valid[i] = 1'b1;
               in_data[i*DW +: DW] = mk_word(i, pidx[i], widx[i], plen[i][pidx[i]]);
               in_eop[i] = (widx[i] == nwords(plen[i][pidx[i]]) - 1);
            end else begin
               in_valid[i] = 1'b0;
               in_data[i*DW +: DW] = '0;
               in_eop[i] = 1'b0;
            end
         end
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         out_ready = stall_en ? (lfsr[1:0] != 2'b00) : 1'b1;
      end
   end

   // output monitor: samples on the falling edge
   initial begin
      forever begin
         @(negedge clk);
         acc = in_valid & in_ready;
         if (rst_n && prev_stall && out_valid)
            chk(out_data == prev_data, "R8", "held word under stall", longint'(out_data), longint'(prev_data));
         prev_stall = out_valid && !out_ready;
         prev_data  = out_data;
         if (rst_n && out_valid && out_ready) begin
            if (!in_pkt) begin
               int q, p;
               q = int'(out_data[23:16]);
               p = int'(out_data[31:24]);
               chk(q == exp_q[ord] && p == exp_p[ord] && out_data[47:32] == 0,
                   cur_req, "grant order queue*100+pkt", q*100 + p, exp_q[ord]*100 + exp_p[ord]);
               ord++;
               in_pkt = 1;
               cur_q = q;
               last_w = 0;
               bad = 0;
               cur_len = int'(out_data[15:0]);
               got_bytes[q] += cur_len;
            end else begin
               if (int'(out_data[23:16]) != cur_q || int'(out_data[47:32]) != last_w + 1) bad = 1;
               last_w = int'(out_data[47:32]);
            end
            if (out_eop) begin
               chk(!bad && last_w == nwords(cur_len) - 1, "R8", "whole packet words",
                   last_w + 1, nwords(cur_len));
               in_pkt = 0;
            end
         end
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", ord, exp_n);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   task automatic begin_case();
      @(negedge clk);
      rst_n = 1'b0;
      stall_en = 0;
      for (int i = 0; i < NQ; i++) begin
         npk[i] = 0; pidx[i] = 0; widx[i] = 0; got_bytes[i] = 0;
      end
      ord = 0;
      in_pkt = 0;
      exp_n = 0;
   endtask

   task automatic load(input int q, input int len);
      plen[q][npk[q]] = len;
      npk[q]++;
   endtask

   // packet-level model of the scheduler
   task automatic build_expect(input int quant, input bit plain_rr);
      int rp [NQ];
      int df [NQ];
      int ptr, total, credit, guard;
      total = 0;
      for (int i = 0; i < NQ; i++) begin rp[i] = 0; df[i] = 0; total += npk[i]; end
      exp_n = 0;
      ptr = 0;
      guard = 0;
      while (exp_n < total && guard < 200000) begin
         guard++;
         if (rp[ptr] >= npk[ptr]) begin
            df[ptr] = 0;
         end else if (plain_rr) begin
            exp_q[exp_n] = ptr; exp_p[exp_n] = rp[ptr]; exp_n++; rp[ptr]++;
         end else begin
            credit = df[ptr] + quant;
            if (credit > 65535) credit = 65535;
            if (plen[ptr][rp[ptr]] <= credit) begin
               exp_q[exp_n] = ptr; exp_p[exp_n] = rp[ptr]; exp_n++;
               df[ptr] = credit - plen[ptr][rp[ptr]];
               rp[ptr]++;
            end else begin
               df[ptr] = credit;
            end
         end
         ptr = (ptr + 1) % NQ;
      end
   endtask

   task automatic wait_done(input string req);
      for (int c = 0; c < 60000; c++) begin
         @(negedge clk);
         if (ord == exp_n && !in_pkt) break;
      end
      chk(ord == exp_n, req, "packets delivered", ord, exp_n);
      for (int i = 0; i < NQ; i++) begin
         int want;
         want = 0;
         for (int k = 0; k < npk[i]; k++) want += plen[i][k];
         if (want != 0 || got_bytes[i] != 0)
            chk(got_bytes[i] == want, req, $sformatf("bytes of queue %0d", i), got_bytes[i], want);
      end
   endtask

   task automatic run_case(input string req, input int quant, input bit plain_rr, input bit stall);
      cur_req = req;
      quantum = 16'(quant);
      stall_en = stall;
      build_expect(quant, plain_rr);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      wait_done(req);
   endtask

   task automatic t_reset();
      begin_case();
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
      chk(in_ready == '0, "R1", "in_ready in reset", in_ready, 0);
      rst_n = 1'b1;
      begin
         bit seen;
         seen = 0;
         for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (out_valid || in_ready != '0) seen = 1;
         end
         chk(!seen, "R1", "idle after reset", seen, 0);
      end
   endtask

   task automatic t_first();
      begin_case();
      load(7, 30); load(1, 10); load(1, 20); load(4, 40);
      run_case("R1", 100, 0, 0);
   endtask

   task automatic t_equal();
      begin_case();
      load(0, 200); load(0, 50); load(1, 201); load(2, 64); load(2, 64);
      run_case("R3", 200, 0, 0);
      begin_case();
      load(1, 201); load(3, 500); load(3, 8); load(6, 9);
      run_case("R5", 200, 0, 0);
      begin_case();
      load(2, 1); load(2, 65); load(4, 17);
      run_case("R2", 64, 0, 0);
   endtask

   task automatic t_carry();
      begin_case();
      load(3, 30); load(3, 30); load(3, 30); load(3, 250);
      load(5, 90); load(5, 90); load(5, 90);
      run_case("R4", 100, 0, 0);
   endtask

   task automatic t_clear();
      int n;
      begin_case();
      load(5, 10);
      run_case("R6", 200, 0, 0);
      repeat (30) @(negedge clk);
      @(negedge clk);
      plen[5][1] = 300;
      npk[5] = 2;
      exp_q[exp_n] = 5; exp_p[exp_n] = 1; exp_n++;
      @(posedge clk);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!out_valid && n < 40);
      chk(n >= 9 && n <= 17, "R6", "grant delay after clear", n, 9);
      wait_done("R6");
   endtask

   task automatic t_stress();
      begin_case();
      for (int i = 0; i < NQ; i++)
         for (int k = 0; k < 6; k++) begin
            int v;
            next_rand(v, 1500);
            load(i, v);
         end
      run_case("R7", 520, 0, 1);
   endtask

   task automatic t_sat();
      begin_case();
      load(0, 1); load(0, 65535); load(1, 10); load(1, 10);
      run_case("R9", 65535, 0, 0);
   endtask

   task automatic t_rr();
      begin_case();
      for (int i = 0; i < NQ; i += 2)
         for (int k = 0; k < 4; k++) begin
            int v;
            next_rand(v, 1500);
            load(i, v);
         end
      run_case("R10", 65535, 1, 1);
   endtask

   initial begin
      for (int i = 0; i < NQ; i++) begin npk[i] = 0; pidx[i] = 0; widx[i] = 0; got_bytes[i] = 0; end
      t_reset();
      t_first();
      t_equal();
      t_carry();
      t_clear();
      t_stress();
      t_sat();
      t_rr();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule